// File: doc/BRIEF.md
# Dual-Timing Synchronous FIFO with Status Flags

This block is a single-clock FIFO for 18-bit words. It has two timing modes. In standard timing, a word reaches the data output only after a read request has been accepted. In fall-through timing, the oldest stored word is always present on the output, and a read request only moves on to the next word. The mode input is captured on each master reset and is held until the next master reset.

Five status flags are produced. Two of them change meaning with the mode. In standard timing they report empty and full. In fall-through timing they report output-ready and input-ready. The other three work the same way in both modes:
- half-full;
- almost-empty, with a threshold measured from the empty side;
- almost-full, with a threshold measured from the full side.

Both thresholds arrive as inputs from a separate offset register block. Each can be set to any value from 0 to the depth.

In fall-through timing, FIFOs can be chained into a deeper queue with no glue logic:
- the output data of one FIFO drives the write data of the next;
- the output-ready flag of the upstream FIFO drives the downstream write enable;
- the input-ready flag of the downstream FIFO drives the upstream read enable.

All flags are active high. DEPTH must be a power of two.

Top module: `mode_fifo`

## Requirements
- R1: `mode_in` is captured only while `rst` is high (1 = fall-through, 0 = standard). Changing `mode_in` after reset has no effect on flag meaning or output timing until the next reset.
- R2: In standard mode, `flag_ef_or` is 1 exactly when no words are stored, and `flag_ff_ir` is 1 exactly when DEPTH words are stored.
- R3: In fall-through mode, `flag_ef_or` is 1 exactly when at least one word is stored, and `flag_ff_ir` is 1 exactly when fewer than DEPTH words are stored.
- R4: In standard mode, an accepted read places the oldest word on `rd_data` after the clock edge. Otherwise `rd_data` holds its value, which is 0 after reset.
- R5: In fall-through mode, `rd_data` shows the oldest stored word whenever the FIFO is not empty, with no read request. This includes the cycle right after the first write to an empty FIFO. An accepted read advances to the next word.
- R6: `flag_half` is 1 exactly when the stored count is greater than DEPTH/2.
- R7: `flag_ae` is 1 exactly when the stored count is less than or equal to `thr_empty`.
- R8: `flag_af` is 1 exactly when the free space (DEPTH minus count) is less than or equal to `thr_full`.
- R9: A write while DEPTH words are stored is dropped, and a read while empty is ignored. Neither changes the count or the order of the stored words.
- R10: A clock edge with `rst` high clears the count and both pointers. After it:
  - standard mode reports empty=1 and full=0;
  - fall-through mode reports output-ready=0 and input-ready=1;
  - `flag_half` reads 0.
- R11: Two fall-through FIFOs chained through their ports behave as one FIFO of twice the depth, with order preserved.
- R12: A write and a read in the same cycle, when neither is blocked, are both accepted. The count stays the same and order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read ports |
| rst | input | 1 | Synchronous master reset, active high |
| mode_in | input | 1 | Timing mode captured at reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Output word |
| thr_empty | input | $clog2(DEPTH)+1 | Almost-empty threshold, in words from empty |
| thr_full | input | $clog2(DEPTH)+1 | Almost-full threshold, in words from full |
| flag_ef_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| flag_ff_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| flag_half | output | 1 | More than half of the depth is occupied |
| flag_ae | output | 1 | Almost empty |
| flag_af | output | 1 | Almost full |

## Verification
Random write/read mixes with seeded probabilities run in both modes. The thresholds are redrawn at intervals, so every flag boundary is crossed from both sides. This separates a flag compared with `<` from one compared with `<=`, and standard output timing from fall-through timing.

Directed fills past full and drains past empty show whether a blocked access disturbs the pointers; any disturbance appears later as a wrong data order.

Changing the mode input with no reset shows whether the mode is truly latched.

A two-stage chain filled beyond one FIFO's depth and then drained shows whether the ready flags hand words across with no loss or duplication.

// File: rtl/mode_fifo_pkg.sv
package mode_fifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/mode_fifo_store.sv
module mode_fifo_store #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mode_fifo_ctrl.sv
module mode_fifo_ctrl
    import mode_fifo_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_in,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] head_data,
    output logic             wr_ok,
    output logic [AW-1:0]    wptr,
    output logic [AW-1:0]    rptr,
    output logic [CW-1:0]    cnt,
    output fifo_mode_e       mode,
    output logic [WIDTH-1:0] rd_reg
);
    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    cnt;
        fifo_mode_e       mode;
        logic [WIDTH-1:0] rdat;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     rd_ok;

    always_comb begin
        st_d  = st_q;
        wr_ok = !rst && wr_en && (st_q.cnt != CW'(DEPTH));
        rd_ok = !rst && rd_en && (st_q.cnt != '0);
        if (wr_ok) begin
            st_d.wptr = st_q.wptr + 1'b1;
        end
        if (rd_ok) begin
            st_d.rptr = st_q.rptr + 1'b1;
            if (st_q.mode == MODE_STD) begin
                st_d.rdat = head_data;
            end
        end
        if (wr_ok && !rd_ok) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (rd_ok && !wr_ok) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rst) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
            st_d.mode = fifo_mode_e'(mode_in);
            st_d.rdat = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wptr   = st_q.wptr;
    assign rptr   = st_q.rptr;
    assign cnt    = st_q.cnt;
    assign mode   = st_q.mode;
    assign rd_reg = st_q.rdat;
endmodule

// File: rtl/mode_fifo_flags.sv
module mode_fifo_flags
    import mode_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic [CW-1:0] cnt,
    input  fifo_mode_e    mode,
    input  logic [CW-1:0] thr_empty,
    input  logic [CW-1:0] thr_full,
    output logic          flag_ef_or,
    output logic          flag_ff_ir,
    output logic          flag_half,
    output logic          flag_ae,
    output logic          flag_af
);
    logic          is_empty;
    logic          is_full;
    logic [CW-1:0] space;

    always_comb begin
        is_empty   = (cnt == '0);
        is_full    = (cnt == CW'(DEPTH));
        space      = CW'(DEPTH) - cnt;
        flag_ef_or = (mode == MODE_FWFT) ? !is_empty : is_empty;
        flag_ff_ir = (mode == MODE_FWFT) ? !is_full : is_full;
        flag_half  = (cnt > CW'(DEPTH / 2));
        flag_ae    = (cnt <= thr_empty);
        flag_af    = (space <= thr_full);
    end
endmodule

// File: rtl/mode_fifo.sv
module mode_fifo
    import mode_fifo_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_in,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [CW-1:0]    thr_empty,
    input  logic [CW-1:0]    thr_full,
    output logic             flag_ef_or,
    output logic             flag_ff_ir,
    output logic             flag_half,
    output logic             flag_ae,
    output logic             flag_af
);
    logic             wr_ok;
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    cnt;
    fifo_mode_e       mode;
    logic [WIDTH-1:0] head_data;
    logic [WIDTH-1:0] rd_reg;

    mode_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (head_data)
    );

    mode_fifo_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode_in   (mode_in),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .head_data (head_data),
        .wr_ok     (wr_ok),
        .wptr      (wptr),
        .rptr      (rptr),
        .cnt       (cnt),
        .mode      (mode),
        .rd_reg    (rd_reg)
    );

    mode_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .cnt        (cnt),
        .mode       (mode),
        .thr_empty  (thr_empty),
        .thr_full   (thr_full),
        .flag_ef_or (flag_ef_or),
        .flag_ff_ir (flag_ff_ir),
        .flag_half  (flag_half),
        .flag_ae    (flag_ae),
        .flag_af    (flag_af)
    );

    assign rd_data = (mode == MODE_FWFT) ? head_data : rd_reg;
endmodule

// File: rtl/mode_fifo_chk.sv
module mode_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [CW-1:0] cnt,
    input logic          mode,
    input logic          flag_ef_or,
    input logic          flag_ff_ir,
    input logic          flag_half
);
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (cnt == '0) && (flag_ef_or == !mode) && (flag_ff_ir == mode) && !flag_half);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(DEPTH)) && wr_en && !rd_en |=> $stable(cnt));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) && rd_en && !wr_en |=> (cnt == '0));

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode));

    p_std_empty_r2: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (flag_ef_or == (cnt == '0)));

    p_fwft_ready_r3: assert property (@(posedge clk) disable iff (rst)
        mode |-> (flag_ff_ir == (cnt != CW'(DEPTH))));

    p_count_step_r12: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || ($past(cnt) == cnt + 1'b1));
endmodule

bind mode_fifo mode_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .cnt        (cnt),
    .mode       (mode),
    .flag_ef_or (flag_ef_or),
    .flag_ff_ir (flag_ff_ir),
    .flag_half  (flag_half)
);

// File: tb/mode_fifo_tb.sv
`timescale 1ns/1ps
module mode_fifo_tb;
    localparam int W  = 18;
    localparam int D  = 16;
    localparam int CW = $clog2(D) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          tb_rd = 1'b0;
    logic          chain = 1'b0;
    logic          dn_rd = 1'b0;
    logic [CW-1:0] thr_e = CW'(3);
    logic [CW-1:0] thr_f = CW'(2);

    logic [W-1:0]  rd_data, dn_data;
    logic          ef, ff, hf, ae, af;
    logic          dn_ef, dn_ff, dn_hf, dn_ae, dn_af;
    logic          dut_rd;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] exp_rd;
    logic         mode_m;

    always #2 clk = ~clk;

    assign dut_rd = chain ? dn_ff : tb_rd;

    mode_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .mode_in(mode_in), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(dut_rd), .rd_data(rd_data), .thr_empty(thr_e), .thr_full(thr_f),
        .flag_ef_or(ef), .flag_ff_ir(ff), .flag_half(hf), .flag_ae(ae), .flag_af(af)
    );

    mode_fifo #(.WIDTH(W), .DEPTH(D)) u_down (
        .clk(clk), .rst(rst), .mode_in(mode_in), .wr_en(chain & ef), .wr_data(rd_data),
        .rd_en(dn_rd), .rd_data(dn_data), .thr_empty(thr_e), .thr_full(thr_f),
        .flag_ef_or(dn_ef), .flag_ff_ir(dn_ff), .flag_half(dn_hf), .flag_ae(dn_ae), .flag_af(dn_af)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_ef(input int c, input logic m);
        return m ? (c != 0) : (c == 0);
    endfunction

    function automatic logic exp_ff(input int c, input logic m);
        return m ? (c != D) : (c == D);
    endfunction

    task automatic check_all();
        int c = q.size();
        chk(mode_m ? "R3 ready-out" : "R2 empty", 32'(ef), 32'(exp_ef(c, mode_m)));
        chk(mode_m ? "R3 ready-in" : "R2 full", 32'(ff), 32'(exp_ff(c, mode_m)));
        chk("R6 half", 32'(hf), 32'(c > D / 2));
        chk("R7 almost-empty", 32'(ae), 32'(c <= int'(thr_e)));
        chk("R8 almost-full", 32'(af), 32'((D - c) <= int'(thr_f)));
        if (!mode_m) chk("R4 std data", 32'(rd_data), 32'(exp_rd));
        else if (c > 0) chk("R5 fwft head", 32'(rd_data), 32'(q[0]));
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        mode_in = m; rst = 1'b1; wr_en = 1'b0; tb_rd = 1'b0; dn_rd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        exp_rd = '0;
        mode_m = m;
    endtask

    task automatic step(input logic w, input logic r, input logic [W-1:0] d);
        int c;
        logic [W-1:0] v;
        wr_en = w; tb_rd = r; wr_data = d;
        @(posedge clk);
        c = q.size();
        if (r && c > 0) begin
            v = q.pop_front();
            if (!mode_m) exp_rd = v;
        end
        if (w && c < D) q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0; tb_rd = 1'b0;
        check_all();
    endtask

    task automatic random_run(input int n, input int wp, input int rp);
        for (int i = 0; i < n; i++) begin
            if (i % 48 == 0) begin
                thr_e = CW'($urandom_range(0, D));
                thr_f = CW'($urandom_range(0, D));
            end
            step(($urandom % 100) < wp, ($urandom % 100) < rp, W'($urandom));
        end
    endtask

    task automatic corner_run();
        int c;
        for (int i = 0; i < D + 2; i++) step(1'b1, 1'b0, W'(18'h100 + i));  // R9 writes past full
        c = q.size();
        chk("R9 count at full", 32'(c), 32'(D));
        step(1'b1, 1'b1, W'(18'h3aaaa));  // R12 (read frees, write ignored when full)
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, '0);
        step(1'b1, 1'b1, W'(18'h2bbbb));  // R12 mid-level simultaneous
        for (int i = 0; i < D + 2; i++) step(1'b0, 1'b1, '0);  // R9 reads past empty
        step(1'b1, 1'b0, W'(18'h15555));
        step(1'b0, 1'b1, '0);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int sent;
        int got;
        void'($urandom(32'd1234));

        // standard mode
        do_reset(1'b0);
        chk("R10 std empty", 32'(ef), 32'd1);
        chk("R10 std full", 32'(ff), 32'd0);
        chk("R10 half", 32'(hf), 32'd0);
        chk("R4 reset data", 32'(rd_data), 32'd0);
        mode_in = 1'b1;  // R1: no reset, must stay standard
        step(1'b0, 1'b0, '0);
        chk("R1 mode latched", 32'(ef), 32'd1);
        step(1'b1, 1'b0, W'(18'h0abcd));
        chk("R1 no fall-through", 32'(rd_data), 32'd0);
        step(1'b0, 1'b1, '0);
        chk("R4 read word", 32'(rd_data), 32'h0abcd);
        thr_e = CW'(3); thr_f = CW'(2);
        corner_run();
        random_run(300, 60, 40);
        random_run(300, 40, 60);

        // fall-through mode
        do_reset(1'b1);
        chk("R10 fwft ready-out", 32'(ef), 32'd0);
        chk("R10 fwft ready-in", 32'(ff), 32'd1);
        chk("R10 half fwft", 32'(hf), 32'd0);
        step(1'b1, 1'b0, W'(18'h2c3c3));
        chk("R5 first word no read", 32'(rd_data), 32'h2c3c3);
        chk("R5 ready with word", 32'(ef), 32'd1);
        corner_run();
        random_run(300, 60, 40);
        random_run(300, 40, 60);

        // chained pair, both fall-through
        do_reset(1'b1);
        chain = 1'b1;
        sent = 0;
        while (sent < D + 4) begin
            @(negedge clk);
            if (ff) begin
                wr_en = 1'b1; wr_data = W'(18'h200 + sent);
                @(posedge clk);
                sent++;
                #0.5 wr_en = 1'b0;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R11 downstream full", 32'(dn_ff), 32'd0);
        chk("R11 upstream holds rest", 32'(ef), 32'd1);
        got = 0;
        for (int i = 0; i < 200 && got < D + 4; i++) begin
            @(negedge clk);
            if (dn_ef) begin
                chk("R11 chained order", 32'(dn_data), 32'(18'h200 + got));
                got++;
                dn_rd = 1'b1;
            end else begin
                dn_rd = 1'b0;
            end
            @(posedge clk);
            #0.5 dn_rd = 1'b0;
        end
        @(negedge clk);
        chk("R11 word total", 32'(got), 32'(D + 4));
        chk("R11 chain drained", 32'(dn_ef), 32'd0);
        chain = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule